// File: doc/BRIEF.md
# Direct Digital Synthesizer Tuning Word Loader

This block is the control front end of a direct digital synthesizer. A 40-bit control word, made of a 32-bit frequency tuning value and an 8-bit phase/control byte, is assembled in a staging register. The staging register is filled in one of two ways. In parallel mode it takes five bytes from an 8-bit bus. In serial mode it takes forty single bits from the top line of that bus. In both modes one item is taken on each rising edge of an asynchronous word-load clock.

A separate update strobe moves the staged word into the active registers and sends the byte pointer back to slot 0. The active tuning value is added to a 32-bit phase accumulator on every reference clock edge. The top five bits of the phase/control byte are added to the upper accumulator bits as a phase offset in steps of one thirty-second of a turn. The sum is the phase output. A master reset clears the pointer, the active registers, the accumulator and the synchronisers. It leaves the staging register untouched, so the staged word can still be applied after a reset.

The assembler is a two-state machine. ASM_OPEN accepts parallel bytes. ASM_FULL ignores parallel bytes. The transition OPEN->FULL is taken when the fifth parallel byte (slot 4) is written. The transition FULL->OPEN is taken on an update edge. A reset forces the machine to OPEN from any state. An update edge seen while in OPEN keeps the machine in OPEN and rewinds the pointer. Serial loading leaves the state and the pointer unchanged.

Top module: `dds_word_loader`

## Requirements
- R1: While reset is high and on every cycle after it falls, `phase_out` is 0, and it stays 0 until an update applies a word, because the active tuning value is cleared.
- R2: In parallel mode (`ser_mode`=0), each rising edge of `wload_clk` writes `din` into the next slot. Slot 0 is the phase/control byte. Slots 1 to 4 are the tuning value, from the most significant byte (bits 31:24) to the least significant byte (bits 7:0). A rising edge of `upd_strobe` applies the staged word.
- R3: In serial mode (`ser_mode`=1), each rising edge of `wload_clk` shifts `din[7]` into the staging register. After 40 edges, the first bit sent is bit 7 of the phase/control byte and the last bit sent is bit 0 of the tuning value.
- R4: A rising edge of `upd_strobe` rewinds the byte pointer, so the next parallel byte goes to slot 0.
- R5: Parallel bytes that arrive after slot 4 has been written (state ASM_FULL) are ignored until the next update edge.
- R6: Master reset clears the byte pointer, the active registers and the accumulator, but not the staging register. An update after reset applies the word that was staged before the reset.
- R7: The accumulator adds the active 32-bit tuning value on every clock edge, modulo 2^32. Two consecutive samples of `phase_out` therefore differ by the tuning value.
- R8: `phase_out` equals the accumulator plus bits 7:3 of the active phase/control byte placed at bits 31:27. Bits 2:0 of that byte have no effect on `phase_out`.
- R9: The active tuning value changes only on an update edge. Loading new bytes without an update leaves the phase step unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Master reset, active high, synchronous |
| wload_clk | input | 1 | Word-load clock (asynchronous; rising edge loads) |
| upd_strobe | input | 1 | Update strobe (asynchronous; rising edge applies) |
| ser_mode | input | 1 | 1 = serial loading on din[7], 0 = parallel bytes |
| din | input | 8 | Data bus; bit 7 is the most significant bit and the serial line |
| phase_out | output | 32 | Current phase: accumulator plus phase offset |

## Verification
The hardest situation to reach from the ports is a word that survives a master reset. The staging register is not visible at the ports, and a reset clears everything that is visible. The bench stages a complete word and pulses reset. It then issues only an update and checks that the exact phase offset reappears.

A second hard case is a pointer that a reset catches partway through a load. The bench writes two bytes, resets, and then writes a full word. It checks that slot 0 holds the new value rather than the old one. The phase offset is swept over all 32 values while the tuning value is held at zero, so each result is exact and does not depend on timing. The phase step is checked for tuning values that wrap the accumulator.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;
    typedef enum logic {
        ASM_OPEN = 1'b0,
        ASM_FULL = 1'b1
    } asm_state_t;
endpackage

// File: rtl/dds_edge_sync.sv
module dds_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES metastability flops plus one flop for edge detection
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/dds_word_asm.sv
module dds_word_asm
    import dds_loader_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int WORD_W = 40,
    parameter int PTR_W  = $clog2(WORD_W / BUS_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_rise,
    input  logic              upd_rise,
    input  logic              ser_mode,
    input  logic [BUS_W-1:0]  din,
    output logic [WORD_W-1:0] word,
    output logic [PTR_W-1:0]  ptr
);
    localparam int NUM_BYTES = WORD_W / BUS_W;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(NUM_BYTES - 1);

    asm_state_t state, state_nx;
    logic       par_wr;

    // an update edge takes priority over a byte arriving in the same cycle
    assign par_wr = wr_rise && !ser_mode && !upd_rise && (state == ASM_OPEN);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ASM_OPEN;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ASM_OPEN: if (par_wr && ptr == LAST_SLOT) state_nx = ASM_FULL;
            ASM_FULL: if (upd_rise) state_nx = ASM_OPEN;
            default:  state_nx = ASM_OPEN;
        endcase
    end

    // outputs: pointer (cleared by reset)
    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (upd_rise) ptr <= '0;
        else if (par_wr)   ptr <= ptr + 1'b1;
    end

    // outputs: staging register (no reset by design)
    always_ff @(posedge clk) begin
        if (wr_rise && !upd_rise) begin
            if (ser_mode) begin
                word <= {word[WORD_W-2:0], din[BUS_W-1]};
            end else if (state == ASM_OPEN) begin
                for (int k = 0; k < NUM_BYTES; k++) begin
                    if (ptr == PTR_W'(k))
                        word[WORD_W-1-k*BUS_W -: BUS_W] <= din;
                end
            end
        end
    end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int FTW_W  = 32,
    parameter int CTRL_W = 8,
    parameter int OFF_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [FTW_W+CTRL_W-1:0] word,
    output logic [FTW_W-1:0]        acc,
    output logic [FTW_W-1:0]        ftw_act,
    output logic [CTRL_W-1:0]       ctl_act,
    output logic [FTW_W-1:0]        phase
);
    localparam int WORD_W = FTW_W + CTRL_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            ftw_act <= '0;
            ctl_act <= '0;
        end else begin
            acc <= acc + ftw_act;
            if (load) begin
                ftw_act <= word[FTW_W-1:0];
                ctl_act <= word[WORD_W-1 -: CTRL_W];
            end
        end
    end

    assign phase = acc + {ctl_act[CTRL_W-1 -: OFF_W], {(FTW_W-OFF_W){1'b0}}};
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
    parameter int FTW_W       = 32,
    parameter int CTRL_W      = 8,
    parameter int BUS_W       = 8,
    parameter int OFF_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wload_clk,
    input  logic             upd_strobe,
    input  logic             ser_mode,
    input  logic [BUS_W-1:0] din,
    output logic [FTW_W-1:0] phase_out
);
    localparam int WORD_W    = FTW_W + CTRL_W;
    localparam int NUM_BYTES = WORD_W / BUS_W;
    localparam int PTR_W     = $clog2(NUM_BYTES + 1);

    logic              wr_rise, upd_rise;
    logic [WORD_W-1:0] staged;
    logic [PTR_W-1:0]  ptr;
    logic [FTW_W-1:0]  acc, ftw_act;
    logic [CTRL_W-1:0] ctl_act;

    dds_edge_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(clk), .rst(rst), .async_in(wload_clk), .rise(wr_rise)
    );

    dds_edge_sync #(.STAGES(SYNC_STAGES)) u_usync (
        .clk(clk), .rst(rst), .async_in(upd_strobe), .rise(upd_rise)
    );

    dds_word_asm #(.BUS_W(BUS_W), .WORD_W(WORD_W), .PTR_W(PTR_W)) u_asm (
        .clk(clk), .rst(rst), .wr_rise(wr_rise), .upd_rise(upd_rise),
        .ser_mode(ser_mode), .din(din), .word(staged), .ptr(ptr)
    );

    dds_phase_acc #(.FTW_W(FTW_W), .CTRL_W(CTRL_W), .OFF_W(OFF_W)) u_acc (
        .clk(clk), .rst(rst), .load(upd_rise), .word(staged),
        .acc(acc), .ftw_act(ftw_act), .ctl_act(ctl_act), .phase(phase_out)
    );
endmodule

// File: rtl/dds_loader_chk.sv
module dds_loader_chk #(
    parameter int FTW_W   = 32,
    parameter int PTR_W   = 3,
    parameter int MAX_PTR = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_rise,
    input logic [PTR_W-1:0] ptr,
    input logic [FTW_W-1:0] acc,
    input logic [FTW_W-1:0] ftw_act,
    input logic [FTW_W-1:0] phase_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (phase_out == '0 && acc == '0));

    // R7
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (acc == $past(acc) + $past(ftw_act)));

    // R9
    ftw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_rise |=> $stable(ftw_act));

    // R4
    ptr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        upd_rise |=> (ptr == '0));

    // R5
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(MAX_PTR));
endmodule

bind dds_word_loader dds_loader_chk #(
    .FTW_W(FTW_W), .PTR_W(PTR_W), .MAX_PTR(NUM_BYTES)
) u_chk (
    .clk(clk), .rst(rst), .upd_rise(upd_rise), .ptr(ptr),
    .acc(acc), .ftw_act(ftw_act), .phase_out(phase_out)
);

// File: tb/sim_dds_word_loader.sv
module sim_dds_word_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wload_clk = 1'b0;
    logic        upd_strobe = 1'b0;
    logic        ser_mode = 1'b0;
    logic [7:0]  din = '0;
    logic [31:0] phase_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dds_word_loader u0 (
        .clk(clk), .rst(rst), .wload_clk(wload_clk), .upd_strobe(upd_strobe),
        .ser_mode(ser_mode), .din(din), .phase_out(phase_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wpulse(input logic [7:0] b);
        din = b;
        tick(1);
        wload_clk = 1'b1;
        tick(4);
        wload_clk = 1'b0;
        tick(4);
    endtask

    task automatic apply();
        upd_strobe = 1'b1;
        tick(4);
        upd_strobe = 1'b0;
        tick(4);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
    endtask

    task automatic load_par(input logic [7:0] pc, input logic [31:0] ftw);
        ser_mode = 1'b0;
        wpulse(pc);
        wpulse(ftw[31:24]);
        wpulse(ftw[23:16]);
        wpulse(ftw[15:8]);
        wpulse(ftw[7:0]);
    endtask

    task automatic load_ser(input logic [7:0] pc, input logic [31:0] ftw);
        logic [39:0] w;
        w = {pc, ftw};
        ser_mode = 1'b1;
        for (int i = 39; i >= 0; i--) wpulse({w[i], 7'b0});
        ser_mode = 1'b0;
    endtask

    task automatic step_of(output logic [31:0] d);
        logic [31:0] p1;
        p1 = phase_out;
        tick(1);
        d = phase_out - p1;
    endtask

    function automatic logic [31:0] offs(input logic [7:0] pc);
        return {pc[7:3], 27'b0};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] ftws [5];
        ftws[0] = 32'h0000_0001;
        ftws[1] = 32'h8000_0000;
        ftws[2] = 32'hFFFF_FFFF;
        ftws[3] = 32'h1234_5678;
        ftws[4] = 32'h00AB_CDEF;

        tick(2);
        chk("R1 during reset", phase_out, 32'h0);
        rst = 1'b0;
        tick(1);
        chk("R1 after reset", phase_out, 32'h0);
        tick(20);
        chk("R1 stays zero", phase_out, 32'h0);

        // R8 / R2: sweep all 32 offsets with zero tuning value, low bits vary
        for (int o = 0; o < 32; o++) begin
            logic [7:0] pc;
            pc = {o[4:0], o[2:0] ^ 3'b101};
            load_par(pc, 32'h0);
            apply();
            chk($sformatf("R8 R2 offset %0d", o), phase_out, offs(pc));
        end

        // R2 / R7: phase step equals tuning value, including wrapping cases
        for (int i = 0; i < 5; i++) begin
            load_par(8'h00, ftws[i]);
            apply();
            step_of(d);
            chk($sformatf("R7 R2 step ftw=%h", ftws[i]), d, ftws[i]);
            step_of(d);
            chk("R7 second step", d, ftws[i]);
        end

        // R9: staging bytes without update leaves step unchanged
        load_par(8'hF8, 32'h0000_0100);
        step_of(d);
        chk("R9 no update no change", d, ftws[4]);
        apply();
        step_of(d);
        chk("R9 applied after update", d, 32'h0000_0100);

        // R3: serial load, exact offset with zero tuning value
        do_reset();
        load_ser(8'hA8, 32'h0);
        apply();
        chk("R3 serial offset", phase_out, offs(8'hA8));
        load_ser(8'h00, 32'h9ABC_DEF1);
        apply();
        step_of(d);
        chk("R3 serial tuning value", d, 32'h9ABC_DEF1);

        // R5: sixth byte ignored
        do_reset();
        load_par(8'h48, 32'h0);
        wpulse(8'hF8);
        apply();
        chk("R5 extra byte ignored", phase_out, offs(8'h48));

        // R4: update rewinds pointer
        do_reset();
        load_par(8'h10, 32'h0);
        apply();
        chk("R4 first word", phase_out, offs(8'h10));
        load_par(8'h38, 32'h0);
        apply();
        chk("R4 second word after rewind", phase_out, offs(8'h38));

        // R6: reset clears pointer mid-load
        do_reset();
        ser_mode = 1'b0;
        wpulse(8'h50);
        wpulse(8'h00);
        do_reset();
        load_par(8'h78, 32'h0);
        apply();
        chk("R6 pointer cleared by reset", phase_out, offs(8'h78));

        // R6: staged word survives reset
        load_par(8'hC0, 32'h0);
        do_reset();
        chk("R6 reset clears output", phase_out, 32'h0);
        apply();
        chk("R6 staged word kept", phase_out, offs(8'hC0));

        load_par(8'h00, 32'h0000_4000);
        do_reset();
        step_of(d);
        chk("R6 reset clears tuning value", d, 32'h0);
        apply();
        step_of(d);
        chk("R6 staged tuning kept", d, 32'h0000_4000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule